// File: doc/BRIEF.md
# Bus Status and Interrupt Event Latch

This block keeps the two read-only registers through which a bus controller reports what happened on the bus: an interrupt register of eight sticky event flags, and a status register. Single-cycle event pulses from the sequencer and the bus monitor set the flags. The status register combines a pending-interrupt flag and four sticky condition flags with the live bus phase. The phase comes straight from the message, control/data and input/output lines.

The host reads a register by raising that register's read strobe. While its strobe is high, a register drives its contents onto its data output; when the strobe is low, the output is zero. Reading the status register changes nothing. Reading the interrupt register returns the collected events. At the clock edge that ends the read, it clears the interrupt flags, the sticky status flags and the pending flag. The interrupt output is the pending flag gated by an enable input. A configuration input can drop the single bus-reset event that results from a bus reset this controller issued itself.

Top module: `bus_event_latch`

## Requirements
- R1: After the hardware reset (rstN low), both registers read 0x00 apart from the live phase bits, and irqOut is low.
- R2: Interrupt register bits are bit 7 bus reset seen, bit 6 illegal command, bit 5 disconnect or timeout, bit 4 service request, bit 3 function complete, bit 2 reselected, bit 1 selected with attention and bit 0 selected without attention. A one-cycle pulse on evIntr[i] sets bit i. The bit stays set, and further events OR into it, until the interrupt register is read.
- R3: Status bit 6 (gross error), bit 5 (parity error), bit 4 (terminal count) and bit 3 (valid group code) are set by statEvt[3], statEvt[2], statEvt[1] and statEvt[0] respectively. They stay set until the interrupt register is read. Condition events alone do not set the pending flag.
- R4: Status bits 2:0 always show {msgLine, cdLine, ioLine} in the same cycle, without latching. The phase codes are 0 data out, 1 data in, 2 command, 3 status, 6 message out and 7 message in.
- R5: Status bit 7 (interrupt pending) is set in the cycle after any recorded interrupt event, whatever the value of irqEn.
- R6: irqOut is high exactly when the pending flag is set and irqEn is high.
- R7: While rdIntr is high, intrData shows the collected events. After that clock edge, the interrupt register, status bits 7:3 and irqOut are all zero unless a new event arrived.
- R8: An interrupt event that arrives in the same cycle as an interrupt register read is not lost. It is returned by the next read and sets the pending flag.
- R9: softRst clears the interrupt register, status bits 7:3 and irqOut at the next edge. Events in that same cycle are discarded.
- R10: When a localRstCmd pulse arrives while suppressLocalRst is 1, the next bus-reset event (evIntr[7]) is dropped and does not set the pending flag. Later bus-reset events are recorded. With suppressLocalRst at 0, no bus-reset event is dropped.
- R11: A status register read (rdStat) changes no latched state, and each data output is 0x00 while its read strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low hardware reset |
| softRst | input | 1 | Software reset strobe |
| evIntr | input | 8 | Interrupt event pulses, one per interrupt register bit |
| statEvt | input | 4 | Condition event pulses for status bits 6:3 |
| msgLine | input | 1 | Live message line |
| cdLine | input | 1 | Live control/data line |
| ioLine | input | 1 | Live input/output line |
| irqEn | input | 1 | Interrupt output enable |
| suppressLocalRst | input | 1 | Drop the bus-reset event caused by an own reset command |
| localRstCmd | input | 1 | Pulse: this controller issued a bus reset |
| rdStat | input | 1 | Status register read strobe |
| rdIntr | input | 1 | Interrupt register read strobe (clears on the edge) |
| statData | output | 8 | Status register read data |
| intrData | output | 8 | Interrupt register read data |
| irqOut | output | 1 | Interrupt request |

## Verification
Single and accumulated interrupt events, read with irqEn low and then high, separate pending from the gated output and show that flags OR together. Condition events with no interrupt event show that status flags are sticky without raising pending. An event aligned with the clearing read, and a soft reset aligned with an event, separate the "keep" rule from the "discard" rule. A sequence of bus-reset events with suppression armed, with suppression disarmed and with suppression off shows that exactly one event is dropped, and only when suppression is armed.

// File: rtl/bus_event_pkg.sv
package bus_event_pkg;
  localparam int INTR_W = 8;
  localparam int SEVT_W = 4;
  localparam int PHASE_W = 3;
  localparam int BUSRST_BIT = INTR_W - 1;

  typedef struct packed {
    logic              clrAll;
    logic [INTR_W-1:0] intrSet;
    logic [SEVT_W-1:0] statSet;
    logic              pendSet;
  } latchCtl_t;
endpackage

// File: rtl/bus_event_ctrl.sv
module bus_event_ctrl
  import bus_event_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              softRst,
  input  logic [INTR_W-1:0] evIntr,
  input  logic [SEVT_W-1:0] statEvt,
  input  logic              suppressLocalRst,
  input  logic              localRstCmd,
  input  logic              rdIntr,
  output latchCtl_t         ctl
);
  logic armedQ;
  logic dropBusRst;
  logic [INTR_W-1:0] dropMask;

  // a bus-reset event consumes the armed suppression
  assign dropBusRst = armedQ & evIntr[BUSRST_BIT];

  always_comb begin
    dropMask = '0;
    dropMask[BUSRST_BIT] = dropBusRst;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armedQ <= 1'b0;
    else if (softRst) armedQ <= 1'b0;
    else if (localRstCmd && suppressLocalRst) armedQ <= 1'b1;
    else if (evIntr[BUSRST_BIT]) armedQ <= 1'b0;
  end

  always_comb begin
    ctl.clrAll  = rdIntr | softRst;
    ctl.intrSet = softRst ? '0 : (evIntr & ~dropMask);
    ctl.statSet = softRst ? '0 : statEvt;
    ctl.pendSet = |ctl.intrSet;
  end
endmodule

// File: rtl/bus_event_dp.sv
module bus_event_dp
  import bus_event_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  latchCtl_t          ctl,
  input  logic [PHASE_W-1:0] phase,
  input  logic               rdStat,
  input  logic               rdIntr,
  output logic [INTR_W-1:0]  intrQ,
  output logic [SEVT_W-1:0]  statQ,
  output logic               pendQ,
  output logic [7:0]         statData,
  output logic [INTR_W-1:0]  intrData
);
  // per-bit sticky flags: a clear keeps only same-cycle arrivals
  for (genvar i = 0; i < INTR_W; i++) begin : g_intr
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) intrQ[i] <= 1'b0;
      else if (ctl.clrAll) intrQ[i] <= ctl.intrSet[i];
      else intrQ[i] <= intrQ[i] | ctl.intrSet[i];
    end
  end

  for (genvar j = 0; j < SEVT_W; j++) begin : g_stat
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) statQ[j] <= 1'b0;
      else if (ctl.clrAll) statQ[j] <= ctl.statSet[j];
      else statQ[j] <= statQ[j] | ctl.statSet[j];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendQ <= 1'b0;
    else if (ctl.clrAll) pendQ <= ctl.pendSet;
    else pendQ <= pendQ | ctl.pendSet;
  end

  assign statData = rdStat ? {pendQ, statQ, phase} : 8'h00;
  assign intrData = rdIntr ? intrQ : '0;
endmodule

// File: rtl/bus_event_latch.sv
module bus_event_latch
  import bus_event_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        softRst,
  input  logic [7:0]  evIntr,
  input  logic [3:0]  statEvt,
  input  logic        msgLine,
  input  logic        cdLine,
  input  logic        ioLine,
  input  logic        irqEn,
  input  logic        suppressLocalRst,
  input  logic        localRstCmd,
  input  logic        rdStat,
  input  logic        rdIntr,
  output logic [7:0]  statData,
  output logic [7:0]  intrData,
  output logic        irqOut
);
  latchCtl_t ctl;
  logic [INTR_W-1:0] intrQ;
  logic [SEVT_W-1:0] statQ;
  logic pendQ;

  bus_event_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .softRst(softRst), .evIntr(evIntr),
    .statEvt(statEvt), .suppressLocalRst(suppressLocalRst),
    .localRstCmd(localRstCmd), .rdIntr(rdIntr), .ctl(ctl)
  );

  bus_event_dp dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .phase({msgLine, cdLine, ioLine}),
    .rdStat(rdStat), .rdIntr(rdIntr), .intrQ(intrQ), .statQ(statQ),
    .pendQ(pendQ), .statData(statData), .intrData(intrData)
  );

  assign irqOut = pendQ & irqEn;
endmodule

// File: rtl/bus_event_latch_chk.sv
module bus_event_latch_chk (
  input logic       clk,
  input logic       rstN,
  input logic       softRst,
  input logic [7:0] evIntr,
  input logic [3:0] statEvt,
  input logic       irqEn,
  input logic       rdIntr,
  input logic [7:0] intrQ,
  input logic [3:0] statQ,
  input logic       pendQ,
  input logic       irqOut
);
  a_r2_intr_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (!rdIntr && !softRst) |=> ((intrQ & $past(intrQ)) == $past(intrQ)));

  a_r3_stat_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (!rdIntr && !softRst) |=> ((statQ & $past(statQ)) == $past(statQ)));

  a_r5_pend_set: assert property (@(posedge clk) disable iff (!rstN)
    (!softRst && evIntr[6:0] != 7'd0) |=> pendQ);

  a_r6_irq_gate: assert property (@(posedge clk) disable iff (!rstN)
    !irqEn |-> !irqOut);

  a_r7_read_clear: assert property (@(posedge clk) disable iff (!rstN)
    (rdIntr && evIntr == 8'd0 && statEvt == 4'd0) |=>
    (intrQ == 8'd0 && statQ == 4'd0 && !pendQ));

  a_r8_same_cycle: assert property (@(posedge clk) disable iff (!rstN)
    (rdIntr && !softRst && evIntr[6:0] != 7'd0) |=>
    (intrQ[6:0] == $past(evIntr[6:0]) && pendQ));

  a_r9_soft_clear: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> (intrQ == 8'd0 && statQ == 4'd0 && !pendQ));
endmodule

bind bus_event_latch bus_event_latch_chk chk_i (
  .clk(clk), .rstN(rstN), .softRst(softRst), .evIntr(evIntr),
  .statEvt(statEvt), .irqEn(irqEn), .rdIntr(rdIntr), .intrQ(intrQ),
  .statQ(statQ), .pendQ(pendQ), .irqOut(irqOut)
);

// File: tb/bus_event_latch_tb_top.sv
module bus_event_latch_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic softRst = 1'b0;
  logic [7:0] evIntr = '0;
  logic [3:0] statEvt = '0;
  logic msgLine = 1'b0, cdLine = 1'b0, ioLine = 1'b0;
  logic irqEn = 1'b0, suppressLocalRst = 1'b0, localRstCmd = 1'b0;
  logic rdStat = 1'b0, rdIntr = 1'b0;
  logic [7:0] statData, intrData;
  logic irqOut;
  int nChecks = 0, nFail = 0;
  logic [7:0] v;

  always #2 clk = ~clk;

  bus_event_latch dut_i (
    .clk(clk), .rstN(rstN), .softRst(softRst), .evIntr(evIntr),
    .statEvt(statEvt), .msgLine(msgLine), .cdLine(cdLine), .ioLine(ioLine),
    .irqEn(irqEn), .suppressLocalRst(suppressLocalRst),
    .localRstCmd(localRstCmd), .rdStat(rdStat), .rdIntr(rdIntr),
    .statData(statData), .intrData(intrData), .irqOut(irqOut)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic [7:0] ei, input logic [3:0] se);
    @(negedge clk); evIntr = ei; statEvt = se;
    @(negedge clk); evIntr = '0; statEvt = '0;
  endtask

  task automatic readIntr(output logic [7:0] val, input logic [7:0] sameEv = 8'h00);
    @(negedge clk); rdIntr = 1'b1; evIntr = sameEv;
    #1 val = intrData;
    @(negedge clk); rdIntr = 1'b0; evIntr = '0;
  endtask

  task automatic readStat(output logic [7:0] val);
    @(negedge clk); rdStat = 1'b1;
    #1 val = statData;
    rdStat = 1'b0;
  endtask

  task automatic t_reset();
    readStat(v); chk("R1 status after reset", v, 8'h00);
    readIntr(v); chk("R1 intr after reset", v, 8'h00);
    chk("R1 irqOut after reset", {7'd0, irqOut}, 8'h00);
    chk("R11 idle statData", statData, 8'h00);
  endtask

  task automatic t_phase();
    logic [2:0] codes [6] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd6, 3'd7};
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); {msgLine, cdLine, ioLine} = codes[k]; rdStat = 1'b1;
      #1 chk("R4 live phase", statData, {5'd0, codes[k]});
      rdStat = 1'b0;
    end
    @(negedge clk); {msgLine, cdLine, ioLine} = 3'd0;
  endtask

  task automatic t_accum();
    irqEn = 1'b0;
    pulse(8'h08, 4'h0);
    pulse(8'h01, 4'h0);
    readStat(v); chk("R5 pending while masked", v, 8'h80);
    chk("R6 irqOut masked", {7'd0, irqOut}, 8'h00);
    irqEn = 1'b1; #1 chk("R6 irqOut enabled", {7'd0, irqOut}, 8'h01);
    readStat(v); chk("R11 status reread", v, 8'h80);
    readIntr(v); chk("R2 accumulated events", v, 8'h09);
    readIntr(v); chk("R7 cleared after read", v, 8'h00);
    readStat(v); chk("R7 status cleared", v, 8'h00);
    chk("R7 irqOut low", {7'd0, irqOut}, 8'h00);
    chk("R11 idle intrData", intrData, 8'h00);
  endtask

  task automatic t_stat();
    pulse(8'h00, 4'b1010);
    readStat(v); chk("R3 sticky condition bits", v, 8'h50);
    @(negedge clk); @(negedge clk);
    readStat(v); chk("R3 still held", v, 8'h50);
    readIntr(v); chk("R3 intr empty", v, 8'h00);
    readStat(v); chk("R3 cleared by intr read", v, 8'h00);
  endtask

  task automatic t_same();
    pulse(8'h20, 4'h0);
    readIntr(v, 8'h02); chk("R8 first read", v, 8'h20);
    readStat(v); chk("R8 pending kept", v, 8'h80);
    readIntr(v); chk("R8 event kept", v, 8'h02);
  endtask

  task automatic t_soft();
    pulse(8'h10, 4'h1);
    @(negedge clk); softRst = 1'b1; evIntr = 8'h04;
    @(negedge clk); softRst = 1'b0; evIntr = '0;
    readStat(v); chk("R9 status cleared", v, 8'h00);
    chk("R9 irqOut low", {7'd0, irqOut}, 8'h00);
    readIntr(v); chk("R9 same-cycle event dropped", v, 8'h00);
  endtask

  task automatic t_suppress();
    suppressLocalRst = 1'b1;
    @(negedge clk); localRstCmd = 1'b1;
    @(negedge clk); localRstCmd = 1'b0;
    pulse(8'h80, 4'h0);
    readStat(v); chk("R10 no pending for own reset", v, 8'h00);
    readIntr(v); chk("R10 own reset dropped", v, 8'h00);
    pulse(8'h80, 4'h0);
    readIntr(v); chk("R10 later reset recorded", v, 8'h80);
    suppressLocalRst = 1'b0;
    @(negedge clk); localRstCmd = 1'b1;
    @(negedge clk); localRstCmd = 1'b0;
    pulse(8'h80, 4'h0);
    readIntr(v); chk("R10 no suppression", v, 8'h80);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_phase();
    t_accum();
    t_stat();
    t_same();
    t_soft();
    t_suppress();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    #400000;
    nChecks++; nFail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule